// File: doc/BRIEF.md
# Video Link Transmit Framer

This block sits in the pixel-clock domain of a serial video link transmitter, ahead of an external 8b/10b encoder. On every pixel clock it samples a 16-bit pixel together with horizontal sync, vertical sync and data enable. It then produces a pair of byte-wide line symbols, each with a flag that marks it as a control (K) or data (D) character. With 10 line bits per symbol, one pixel clock carries 20 line bits.

Sync inputs are normalized to active high under a polarity strap. Any change of sync state is sent as a control pair that encodes the new state. Each horizontal sync rising edge starts with the comma-bearing alignment code, so that a receiver that was plugged in while the link ran can lock again on the next line.

Side-channel bytes from a local valid/ready source are carried only in the first lines of vertical blanking, which by default is two lines. They are framed by start and end codes and padded with an idle code when no byte is offered. No more than a fixed number of bytes, 224 by default, are sent per frame. The count of bytes sent in the current frame is reported.

Top module: `vlink_tx_framer`

## Requirements
- R1: Outputs are registered with one pixel clock of latency. When data enable is high and the sync state is unchanged, the next cycle shows sym0 = pixel[15:8] and sym1 = pixel[7:0], with both K flags 0.
- R2: When sync_pol_i = 1, hsync_i and vsync_i are active low. When it is 0 they are active high. All behaviour uses the normalized (active-high) levels.
- R3: A cycle whose normalized {vsync,hsync} differs from the previous cycle has priority over everything else. sym0 = 0xBC if hsync rose, otherwise 0xFC. sym1 = 0x1C + 32*{vsync,hsync}, which gives 0x1C, 0x3C, 0x5C or 0x7C. Both are K.
- R4: Outside data enable, with no sync change and no side-channel activity, both symbols are 0xBLANK = 0x9C (K) and the pixel inputs have no effect.
- R5: A vsync rising edge opens the side-channel window, which closes at the second hsync rising edge after it. The first eligible cycle in the window (no sync change, data enable low) sends 0xFB on both symbols (K).
- R6: After the start code, each eligible window cycle sends either an accepted byte as sym0 (D) with sym1 = 0xF7 (K), or 0xF7 on both symbols (K) when no byte is taken.
- R7: aux_ready_o is high only in an eligible window cycle after the start code has been sent and while fewer than 224 bytes have been taken this frame. A byte is taken when aux_valid_i and aux_ready_o are both high.
- R8: aux_count_o clears on vsync rising, rises by one for each taken byte, never exceeds 224, and holds until the next vsync rising.
- R9: After the window closes, the first eligible cycle sends 0xFD on both symbols (K).
- R10: While rst_ni is low, both symbols are 0x9C with K set and aux_count_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 16 | Pixel data |
| hsync_i | input | 1 | Horizontal sync, raw polarity |
| vsync_i | input | 1 | Vertical sync, raw polarity |
| de_i | input | 1 | Data enable, active high |
| sync_pol_i | input | 1 | 1: syncs active low, 0: active high |
| aux_data_i | input | 8 | Side-channel byte |
| aux_valid_i | input | 1 | Side-channel byte offered |
| aux_ready_o | output | 1 | Side-channel byte accepted this cycle |
| sym0_o | output | 8 | First line symbol |
| sym0_k_o | output | 1 | First symbol is a control code |
| sym1_o | output | 8 | Second line symbol |
| sym1_k_o | output | 1 | Second symbol is a control code |
| aux_count_o | output | 8 | Side-channel bytes sent in this frame |

## Verification
The hardest situation to reach is the byte cap. It needs a window line long enough to hold more than 224 eligible cycles with the source always valid, followed by a closing hsync, so that the ready drop, the held count and the end code are all seen in one frame. The stimulus builds a second frame with inverted sync polarity and 300-cycle blanking lines with the source held valid. The first frame mixes sparse offers, a data-enable burst and an hsync pulse inside the window, which covers the ordering between start, payload, sync and end codes.

// File: rtl/vlink_pkg.sv
package vlink_pkg;
  localparam int SYM_W = 8;

  localparam logic [SYM_W-1:0] K_ALIGN    = 8'hBC;
  localparam logic [SYM_W-1:0] K_SYNC     = 8'hFC;
  localparam logic [SYM_W-1:0] K_BLANK    = 8'h9C;
  localparam logic [SYM_W-1:0] K_SC_START = 8'hFB;
  localparam logic [SYM_W-1:0] K_SC_END   = 8'hFD;
  localparam logic [SYM_W-1:0] K_SC_IDLE  = 8'hF7;

  typedef enum logic [2:0] {
    SEL_BLANK, SEL_SYNC, SEL_PIX, SEL_END, SEL_START, SEL_AUX, SEL_IDLE
  } sym_sel_e;

  // sync state code: 0x1C with {vs,hs} in bits 6:5
  function automatic logic [SYM_W-1:0] sync_code(input logic vs, input logic hs);
    return 8'h1C | {1'b0, vs, hs, 5'b0};
  endfunction
endpackage

// File: rtl/vlink_sync_norm.sv
module vlink_sync_norm #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic         pol_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic         chg_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_sync
    assign lvl_o[i]  = raw_i[i] ^ pol_i;
    assign rise_o[i] = lvl_o[i] & ~prev_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= lvl_o[i];
    end
  end

  assign chg_o = |(lvl_o ^ prev_q);
endmodule

// File: rtl/vlink_aux_window.sv
module vlink_aux_window #(
  parameter int AUX_MAX   = 224,
  parameter int AUX_LINES = 2,
  parameter int CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_rise_i,
  input  logic             vs_rise_i,
  input  logic             chg_i,
  input  logic             de_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             take_o,
  output logic             emit_start_o,
  output logic             emit_end_o,
  output logic             payload_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int LINE_W = (AUX_LINES > 1) ? $clog2(AUX_LINES) : 1;

  logic              win_q, start_q, endp_q;
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              eligible;

  assign eligible     = !chg_i && !de_i;
  assign emit_end_o   = eligible && endp_q;
  assign emit_start_o = eligible && win_q && !start_q;
  assign payload_o    = eligible && win_q && start_q;
  assign ready_o      = payload_o && (cnt_q < CNT_W'(AUX_MAX));
  assign take_o       = ready_o && valid_i;
  assign count_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= 1'b0;
      start_q <= 1'b0;
      endp_q  <= 1'b0;
      line_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (emit_start_o) start_q <= 1'b1;
      if (emit_end_o)   endp_q  <= 1'b0;
      if (take_o)       cnt_q   <= cnt_q + 1'b1;
      // emit_* need a quiet sync, so they never coincide with the edges below
      if (vs_rise_i) begin
        win_q   <= 1'b1;
        line_q  <= '0;
        start_q <= 1'b0;
        endp_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (win_q && hs_rise_i) begin
        if (line_q == LINE_W'(AUX_LINES - 1)) begin
          win_q  <= 1'b0;
          endp_q <= 1'b1;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vlink_sym_mux.sv
module vlink_sym_mux
  import vlink_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  sym_sel_e           sel_i,
  input  logic [2*SYM_W-1:0] pix_i,
  input  logic               vs_i,
  input  logic               hs_i,
  input  logic               hs_rise_i,
  input  logic [SYM_W-1:0]   aux_i,
  output logic [SYM_W-1:0]   sym0_o,
  output logic               sym0_k_o,
  output logic [SYM_W-1:0]   sym1_o,
  output logic               sym1_k_o
);
  logic [SYM_W-1:0] s0_d, s1_d;
  logic             k0_d, k1_d;

  always_comb begin
    s0_d = K_BLANK; k0_d = 1'b1;
    s1_d = K_BLANK; k1_d = 1'b1;
    unique case (sel_i)
      SEL_SYNC: begin
        s0_d = hs_rise_i ? K_ALIGN : K_SYNC;
        s1_d = sync_code(vs_i, hs_i);
      end
      SEL_PIX: begin
        s0_d = pix_i[2*SYM_W-1:SYM_W]; k0_d = 1'b0;
        s1_d = pix_i[SYM_W-1:0];       k1_d = 1'b0;
      end
      SEL_END:   begin s0_d = K_SC_END;   s1_d = K_SC_END;   end
      SEL_START: begin s0_d = K_SC_START; s1_d = K_SC_START; end
      SEL_AUX: begin
        s0_d = aux_i; k0_d = 1'b0;
        s1_d = K_SC_IDLE;
      end
      SEL_IDLE:  begin s0_d = K_SC_IDLE;  s1_d = K_SC_IDLE;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym0_o <= K_BLANK; sym0_k_o <= 1'b1;
      sym1_o <= K_BLANK; sym1_k_o <= 1'b1;
    end else begin
      sym0_o <= s0_d; sym0_k_o <= k0_d;
      sym1_o <= s1_d; sym1_k_o <= k1_d;
    end
  end
endmodule

// File: rtl/vlink_tx_framer.sv
module vlink_tx_framer
  import vlink_pkg::*;
#(
  parameter int AUX_MAX   = 224,
  parameter int AUX_LINES = 2,
  localparam int CNT_W    = $clog2(AUX_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*SYM_W-1:0] pix_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  input  logic               sync_pol_i,
  input  logic [SYM_W-1:0]   aux_data_i,
  input  logic               aux_valid_i,
  output logic               aux_ready_o,
  output logic [SYM_W-1:0]   sym0_o,
  output logic               sym0_k_o,
  output logic [SYM_W-1:0]   sym1_o,
  output logic               sym1_k_o,
  output logic [CNT_W-1:0]   aux_count_o
);
  logic [1:0] lvl, rise;
  logic       sync_chg, hs_rise;
  logic       take, emit_start, emit_end, payload;
  sym_sel_e   sel;

  vlink_sync_norm #(.N(2)) u_sync (
    .clk_i, .rst_ni,
    .raw_i  ({vsync_i, hsync_i}),
    .pol_i  (sync_pol_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .chg_o  (sync_chg)
  );

  assign hs_rise = rise[0];

  vlink_aux_window #(.AUX_MAX(AUX_MAX), .AUX_LINES(AUX_LINES), .CNT_W(CNT_W)) u_win (
    .clk_i, .rst_ni,
    .hs_rise_i    (hs_rise),
    .vs_rise_i    (rise[1]),
    .chg_i        (sync_chg),
    .de_i         (de_i),
    .valid_i      (aux_valid_i),
    .ready_o      (aux_ready_o),
    .take_o       (take),
    .emit_start_o (emit_start),
    .emit_end_o   (emit_end),
    .payload_o    (payload),
    .count_o      (aux_count_o)
  );

  always_comb begin
    if (sync_chg)        sel = SEL_SYNC;
    else if (de_i)       sel = SEL_PIX;
    else if (emit_end)   sel = SEL_END;
    else if (emit_start) sel = SEL_START;
    else if (take)       sel = SEL_AUX;
    else if (payload)    sel = SEL_IDLE;
    else                 sel = SEL_BLANK;
  end

  vlink_sym_mux u_mux (
    .clk_i, .rst_ni,
    .sel_i     (sel),
    .pix_i     (pix_i),
    .vs_i      (lvl[1]),
    .hs_i      (lvl[0]),
    .hs_rise_i (hs_rise),
    .aux_i     (aux_data_i),
    .sym0_o, .sym0_k_o, .sym1_o, .sym1_k_o
  );
endmodule

// File: rtl/vlink_tx_framer_chk.sv
module vlink_tx_framer_chk
  import vlink_pkg::*;
#(
  parameter int AUX_MAX = 224,
  parameter int CNT_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             de_i,
  input logic             aux_valid_i,
  input logic             ready_i,
  input logic [CNT_W-1:0] count_i,
  input logic [SYM_W-1:0] sym0_i,
  input logic             sym0_k_i,
  input logic             sym1_k_i,
  input logic             hs_rise_i,
  input logic             chg_i
);
  // R8
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(AUX_MAX));
  // R8
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_valid_i && ready_i) |=> count_i == $past(count_i) + 1'b1);
  // R7
  ready_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |-> !ready_i);
  // R7
  ready_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |-> !ready_i);
  // R3
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_rise_i |=> (sym0_i == K_ALIGN) && sym0_k_i);
  // R1
  data_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_i && !chg_i) |=> !sym0_k_i && !sym1_k_i);
endmodule

bind vlink_tx_framer vlink_tx_framer_chk #(.AUX_MAX(AUX_MAX), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .de_i        (de_i),
  .aux_valid_i (aux_valid_i),
  .ready_i     (aux_ready_o),
  .count_i     (aux_count_o),
  .sym0_i      (sym0_o),
  .sym0_k_i    (sym0_k_o),
  .sym1_k_i    (sym1_k_o),
  .hs_rise_i   (hs_rise),
  .chg_i       (sync_chg)
);

// File: tb/vlink_tx_framer_bench.sv
module vlink_tx_framer_bench;
  localparam int AUX_MAX = 224;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pix = '0;
  logic        hsync = 1'b0, vsync = 1'b0, de = 1'b0, pol_pin = 1'b0;
  logic [7:0]  aux_data = '0;
  logic        aux_valid = 1'b0;
  logic        aux_ready;
  logic [7:0]  sym0, sym1, aux_count;
  logic        sym0_k, sym1_k;

  always #4 clk = ~clk;

  vlink_tx_framer u_vlink_tx_framer (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .hsync_i(hsync), .vsync_i(vsync),
    .de_i(de), .sync_pol_i(pol_pin), .aux_data_i(aux_data), .aux_valid_i(aux_valid),
    .aux_ready_o(aux_ready), .sym0_o(sym0), .sym0_k_o(sym0_k), .sym1_o(sym1),
    .sym1_k_o(sym1_k), .aux_count_o(aux_count)
  );

  typedef struct {
    logic [17:0] syms;
    int          cnt;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   pol = 0;
  bit   cur_hs = 0, cur_vs = 0;
  // reference state
  bit   m_hs = 0, m_vs = 0, m_win = 0, m_start = 0, m_endp = 0;
  int   m_line = 0, m_cnt = 0;

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic [15:0] p, bit hs, bit vs, bit d, bit v, logic [7:0] b);
    bit chg, hsr, vsr, elig, rdy;
    exp_t it;
    @(negedge clk);
    pol_pin = pol; hsync = hs ^ pol; vsync = vs ^ pol;
    de = d; pix = p; aux_valid = v; aux_data = b;
    cur_hs = hs; cur_vs = vs;
    chg  = (hs != m_hs) || (vs != m_vs);
    hsr  = hs && !m_hs;
    vsr  = vs && !m_vs;
    elig = !chg && !d;
    rdy  = elig && m_win && m_start && (m_cnt < AUX_MAX);
    #1 cmp("R7", aux_ready, rdy);
    if (chg) begin
      it.syms = {(hsr ? 8'hBC : 8'hFC), 1'b1, 8'h1C + 8'({vs, hs}) * 8'd32, 1'b1};
      it.req = "R3";
    end else if (d) begin
      it.syms = {p[15:8], 1'b0, p[7:0], 1'b0}; it.req = "R1";
    end else if (m_endp) begin
      it.syms = {8'hFD, 1'b1, 8'hFD, 1'b1}; it.req = "R9"; m_endp = 0;
    end else if (m_win && !m_start) begin
      it.syms = {8'hFB, 1'b1, 8'hFB, 1'b1}; it.req = "R5"; m_start = 1;
    end else if (rdy && v) begin
      it.syms = {b, 1'b0, 8'hF7, 1'b1}; it.req = "R6"; m_cnt++;
    end else if (m_win && m_start) begin
      it.syms = {8'hF7, 1'b1, 8'hF7, 1'b1}; it.req = "R6";
    end else begin
      it.syms = {8'h9C, 1'b1, 8'h9C, 1'b1}; it.req = "R4";
    end
    if (vsr) begin
      m_win = 1; m_line = 0; m_start = 0; m_endp = 0; m_cnt = 0;
    end else if (m_win && hsr) begin
      if (m_line == 1) begin m_win = 0; m_endp = 1; end
      else m_line++;
    end
    m_hs = hs; m_vs = vs;
    it.cnt = m_cnt;
    if (pol) it.req = {"R2 ", it.req};
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    exp_t it;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      cmp(it.req, 32'({sym0, sym0_k, sym1, sym1_k}), 32'(it.syms));
      cmp("R8", 32'(aux_count), 32'(it.cnt));
    end
  end

  task automatic blank(int n, bit v);
    for (int i = 0; i < n; i++) step(16'hA5A5 ^ 16'(i * 37), cur_hs, cur_vs, 0, v, 8'(i + 1));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10 reset state
    cmp("R10", 32'({sym0, sym0_k, sym1, sym1_k}), 32'({8'h9C, 1'b1, 8'h9C, 1'b1}));
    cmp("R10", 32'(aux_count), 0);
    @(negedge clk); rst_n = 1'b1;

    blank(3, 0);                                   // R4 pixels ignored
    for (int i = 0; i < 8; i++) step(16'h1234 + 16'(i * 16'h0F0F), 0, 0, 1, 0, 8'h00); // R1
    step(16'h0, 1, 0, 0, 0, 8'h0);                 // R3 hsync rise
    step(16'h0, 0, 0, 0, 0, 8'h0);                 // R3 hsync fall
    step(16'hBEEF, 1, 0, 1, 0, 8'h0);              // R3 wins over data enable
    step(16'hCAFE, 1, 0, 1, 0, 8'h0);
    step(16'h0, 0, 0, 0, 0, 8'h0);

    // frame one: sparse offers, DE burst and hsync pulse in the window
    step(16'h0, 0, 1, 0, 1, 8'h11);                // R5 open window
    for (int i = 0; i < 12; i++) step(16'h0, 0, 1, 0, i[0], 8'h20 + 8'(i)); // R5 R6
    step(16'h7777, 0, 1, 1, 1, 8'h99);             // R7 no ready under DE
    step(16'h0, 1, 1, 0, 1, 8'h40);                // line 1 hsync
    step(16'h0, 1, 1, 0, 1, 8'h41);
    step(16'h0, 0, 1, 0, 1, 8'h42);
    for (int i = 0; i < 6; i++) step(16'h0, 0, 1, 0, 1, 8'h50 + 8'(i));
    step(16'h0, 1, 1, 0, 1, 8'h60);                // closes window
    step(16'h0, 1, 1, 0, 1, 8'h61);                // R9 end code
    step(16'h0, 1, 1, 0, 1, 8'h62);                // R8 count held, R7 no ready
    step(16'h0, 0, 0, 0, 1, 8'h63);
    blank(4, 1);

    // frame two: active-low syncs, cap reached
    pol = 1;
    blank(3, 0);                                   // R2 same logical levels
    step(16'h0, 0, 1, 0, 1, 8'h00);                // R2 vsync rise, count clears
    blank(300, 1);                                 // R8 cap at 224
    step(16'h0, 1, 1, 0, 1, 8'h00);
    step(16'h0, 0, 1, 0, 1, 8'h00);
    blank(20, 1);
    step(16'h0, 1, 1, 0, 1, 8'h00);                // window closes
    step(16'h0, 1, 1, 0, 1, 8'h00);                // R9
    step(16'h0, 0, 0, 0, 0, 8'h00);
    step(16'h0, 0, 1, 0, 0, 8'h00);                // next frame clears count (R8)
    blank(3, 0);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule